// File: doc/BRIEF.md
# Dual-Compare Up-Counting Interval Timer

This block is a 16-bit interval timer that counts upward from zero on each cycle in which a clock-enable tick is present. When counting starts, the value of compare register A is frozen as the period. Each time the count would reach that period, the timer emits a period pulse and begins again at zero. Two further single-cycle pulses report a match of the running count with the live compare-A register and with compare register B. The compare-B match is independent of the period, so it can place a second event anywhere inside each period.

Software controls the timer through a small byte-addressed register port. A two-byte mode register holds free control bits and the count-enable and load bits. Two single-byte capture/compare mode registers are stored and read back. The two compare registers take byte or halfword accesses, and a read-only counter can be read. An access that is badly sized, unmapped, aimed at the counter for writing, or that sets reserved or conflicting mode bits has no effect and raises an access-error flag for one cycle.

Top module: `upcmp_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, and `rdata`, `acc_err` and all three pulse outputs are 0.
- R2: The map is: mode low byte 0x84, mode high byte 0x85, counter 0xA4 (read-only), mode A 0xB4, mode B 0xB5, compare A 0xC4, compare B 0xD4. `size` 0 means one byte and 1 means two bytes. Two-byte access is legal only at 0x84, 0xA4, 0xC4 and 0xD4. Any other size or address, and any write to 0xA4, is an error. An access that is an error changes no register, returns `rdata` 0, and drives `acc_err` high for the one cycle after it. Mode A and mode B store a written byte and read it back.
- R3: A write is an error and is dropped if the low mode byte has any of bits 5, 3 or 2 set, or if the high mode byte has any of bits 2:0 set or has bit 7 (count enable) and bit 6 (load) both set.
- R4: A counter read returns 0 while stopped. While running it returns the number of tick cycles since the start, modulo the period. The count advances only in cycles where `tick` is 1.
- R5: A legal write that sets high-mode bit 7 clears the count and latches compare A as the period P. When the count would become P, it returns to 0 instead and `period_pulse` is high for one cycle, so a pulse comes every P ticks. If P is 0, the period is 65536 ticks.
- R6: `cmpa_pulse` is high for one cycle after a tick that takes the count to the current compare-A register value. A compare-A write made while running moves this pulse but not the period.
- R7: `cmpb_pulse` is high for one cycle after a tick that leaves the count equal to compare B. This includes a value of 0 on a wrap.
- R8: A legal write that clears high-mode bit 7 stops the timer and zeroes the count. From then on no pulse appears until counting is enabled again.
- R9: In a two-byte access, `wdata[7:0]` and `rdata[7:0]` carry the byte at the lower address (0x84 low byte, compare low byte), and `[15:8]` carries the byte above it. A one-byte write to a compare register replaces the whole register with the byte zero-extended, and a one-byte read returns the low byte.
- R10: Setting count enable while already running restarts the count from 0 and relatches the period from compare A.
- R11: Read data appears on `rdata` in the cycle after `rd_en` and holds the value from before that clock edge. In every other cycle `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| size | input | 2 | Access size: 0 one byte, 1 two bytes |
| wdata | input | 16 | Write data, lower address in bits 7:0 |
| rdata | output | 16 | Registered read data |
| acc_err | output | 1 | One-cycle access-error flag |
| period_pulse | output | 1 | Period reached, count restarted |
| cmpa_pulse | output | 1 | Count matched compare A |
| cmpb_pulse | output | 1 | Count matched compare B |

## Verification
On every cycle, the assertions check that a period pulse leaves the count at zero and that a running count stays below a nonzero latched period. They also check that no pulse appears unless the timer was running, that a compare-B pulse agrees with the register value it matched, and that a rejected access changes no register and returns no data. Whether the pulses come at the right spacing cannot be seen from any single cycle, and the same holds for zero-extension, byte-lane order and restart behaviour. These are shown by the bench's reference model, which tracks every cycle, and by its directed scenarios with fixed expected values. Those scenarios include a 65536-tick period and a tick present only every third cycle.

// File: rtl/upcmp_pkg.sv
package upcmp_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE_LO = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI = 8'h85;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'hA4;
  localparam logic [ADDR_W-1:0] OFS_CMODE_A = 8'hB4;
  localparam logic [ADDR_W-1:0] OFS_CMODE_B = 8'hB5;
  localparam logic [ADDR_W-1:0] OFS_CMP_A   = 8'hC4;
  localparam logic [ADDR_W-1:0] OFS_CMP_B   = 8'hD4;

  localparam logic [BYTE_W-1:0] RSV_LO_MASK = 8'h2C;
  localparam logic [BYTE_W-1:0] RSV_HI_MASK = 8'h07;
  localparam int RUN_BIT  = 7;
  localparam int LOAD_BIT = 6;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE_LO, SEL_MODE_HI, SEL_COUNT,
    SEL_CMODE_A, SEL_CMODE_B, SEL_CMP_A, SEL_CMP_B
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_MODE_LO: return SEL_MODE_LO;
      OFS_MODE_HI: return SEL_MODE_HI;
      OFS_COUNT:   return SEL_COUNT;
      OFS_CMODE_A: return SEL_CMODE_A;
      OFS_CMODE_B: return SEL_CMODE_B;
      OFS_CMP_A:   return SEL_CMP_A;
      OFS_CMP_B:   return SEL_CMP_B;
      default:     return SEL_NONE;
    endcase
  endfunction

  function automatic logic half_ok(input reg_sel_e s);
    return (s == SEL_MODE_LO) || (s == SEL_COUNT) ||
           (s == SEL_CMP_A) || (s == SEL_CMP_B);
  endfunction

  function automatic logic lo_byte_ok(input logic [BYTE_W-1:0] b);
    return (b & RSV_LO_MASK) == '0;
  endfunction

  function automatic logic hi_byte_ok(input logic [BYTE_W-1:0] b);
    return ((b & RSV_HI_MASK) == '0) && !(b[RUN_BIT] && b[LOAD_BIT]);
  endfunction

  function automatic logic [DATA_W-1:0] fit_size(input logic [DATA_W-1:0] v,
                                                 input logic [1:0] sz);
    if (sz == SZ_HALF) return v;
    return {{(DATA_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
  endfunction

  function automatic logic period_hit(input logic [DATA_W-1:0] cnt,
                                      input logic [DATA_W-1:0] period);
    logic [DATA_W-1:0] inc;
    inc = cnt + 1'b1;
    return inc == period;
  endfunction

  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cnt,
                                                   input logic [DATA_W-1:0] period);
    logic [DATA_W-1:0] inc;
    inc = cnt + 1'b1;
    return (inc == period) ? '0 : inc;
  endfunction
endpackage

// File: rtl/upcmp_decode.sv
module upcmp_decode
  import upcmp_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output reg_sel_e          sel,
  output logic              bad,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_ma,
  output logic              wr_mb,
  output logic              wr_ca,
  output logic              wr_cb,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [DATA_W-1:0] cmp_val
);
  logic active, size_bad, content_bad, good_wr, lo_touch, hi_touch;

  always_comb begin
    sel      = decode_ofs(addr);
    active   = wr_en | rd_en;
    size_bad = (size > SZ_HALF) || ((size == SZ_HALF) && !half_ok(sel));
    lo_touch = (sel == SEL_MODE_LO);
    hi_touch = (sel == SEL_MODE_HI) || ((sel == SEL_MODE_LO) && (size == SZ_HALF));
    lo_byte  = wdata[BYTE_W-1:0];
    hi_byte  = (sel == SEL_MODE_LO) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
    content_bad = wr_en && ((sel == SEL_COUNT) ||
                            (lo_touch && !lo_byte_ok(lo_byte)) ||
                            (hi_touch && !hi_byte_ok(hi_byte)));
    bad      = active && ((sel == SEL_NONE) || size_bad || content_bad);
    good_wr  = wr_en && !bad;
    wr_lo    = good_wr && lo_touch;
    wr_hi    = good_wr && hi_touch;
    wr_ma    = good_wr && (sel == SEL_CMODE_A);
    wr_mb    = good_wr && (sel == SEL_CMODE_B);
    wr_ca    = good_wr && (sel == SEL_CMP_A);
    wr_cb    = good_wr && (sel == SEL_CMP_B);
    cmp_val  = fit_size(wdata, size);
  end
endmodule

// File: rtl/upcmp_regs.sv
module upcmp_regs
  import upcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [1:0]        size,
  input  logic              bad,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ma,
  input  logic              wr_mb,
  input  logic              wr_ca,
  input  logic              wr_cb,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic [DATA_W-1:0] cnt,
  output logic              run,
  output logic [DATA_W-1:0] cmp_a,
  output logic [DATA_W-1:0] cmp_b,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_err
);
  logic [BYTE_W-1:0] mode_lo_q, mode_hi_q, cmode_a_q, cmode_b_q;
  logic [DATA_W-1:0] cmp_a_q, cmp_b_q, rd_mux;
  logic              rd_take;

  assign run   = mode_hi_q[RUN_BIT];
  assign cmp_a = cmp_a_q;
  assign cmp_b = cmp_b_q;
  assign rd_take = rd_en && !wr_en && !bad;

  always_comb begin
    case (sel)
      SEL_MODE_LO: rd_mux = fit_size({mode_hi_q, mode_lo_q}, size);
      SEL_MODE_HI: rd_mux = {{(DATA_W-BYTE_W){1'b0}}, mode_hi_q};
      SEL_COUNT:   rd_mux = fit_size(cnt, size);
      SEL_CMODE_A: rd_mux = {{(DATA_W-BYTE_W){1'b0}}, cmode_a_q};
      SEL_CMODE_B: rd_mux = {{(DATA_W-BYTE_W){1'b0}}, cmode_b_q};
      SEL_CMP_A:   rd_mux = fit_size(cmp_a_q, size);
      SEL_CMP_B:   rd_mux = fit_size(cmp_b_q, size);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      cmode_a_q <= '0;
      cmode_b_q <= '0;
      cmp_a_q   <= '0;
      cmp_b_q   <= '0;
      rdata     <= '0;
      acc_err   <= 1'b0;
    end else begin
      if (wr_lo) mode_lo_q <= lo_byte;
      if (wr_hi) mode_hi_q <= hi_byte;
      if (wr_ma) cmode_a_q <= lo_byte;
      if (wr_mb) cmode_b_q <= lo_byte;
      if (wr_ca) cmp_a_q   <= cmp_val;
      if (wr_cb) cmp_b_q   <= cmp_val;
      rdata   <= rd_take ? rd_mux : '0;
      acc_err <= bad;
    end
  end

  AST_BAD_LEAVES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ($stable(mode_lo_q) && $stable(mode_hi_q) && $stable(cmode_a_q) &&
                 $stable(cmode_b_q) && $stable(cmp_a_q) && $stable(cmp_b_q))); // R2
  AST_BAD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (rdata == '0)); // R2
  AST_RUN_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_hi_q[RUN_BIT] && mode_hi_q[LOAD_BIT])); // R3
endmodule

// File: rtl/upcmp_core.sv
module upcmp_core
  import upcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              stop,
  input  logic              run,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output logic [DATA_W-1:0] cnt,
  output logic              period_pulse,
  output logic              cmpa_pulse,
  output logic              cmpb_pulse
);
  logic [DATA_W-1:0] cnt_q, period_q, inc, nxt;
  logic              hit, ev_adv;

  assign inc    = cnt_q + 1'b1;
  assign nxt    = count_step(cnt_q, period_q);
  assign hit    = period_hit(cnt_q, period_q);
  assign ev_adv = run && tick && !start && !stop;
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      period_q     <= '0;
      period_pulse <= 1'b0;
      cmpa_pulse   <= 1'b0;
      cmpb_pulse   <= 1'b0;
    end else begin
      period_pulse <= 1'b0;
      cmpa_pulse   <= 1'b0;
      cmpb_pulse   <= 1'b0;
      if (start) begin
        cnt_q    <= '0;
        period_q <= cmp_a;
      end else if (stop || !run) begin
        cnt_q <= '0;
      end else if (ev_adv) begin
        cnt_q        <= nxt;
        period_pulse <= hit;
        cmpa_pulse   <= (inc == cmp_a);
        cmpb_pulse   <= (nxt == cmp_b);
      end
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |-> (cnt_q == '0)); // R5
  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (period_q != '0)) |-> (cnt_q < period_q)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt_q == '0)); // R8
  AST_PULSES_NEED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (period_pulse || cmpa_pulse || cmpb_pulse) |-> $past(run)); // R8
  AST_CMPB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmpb_pulse |-> (cnt_q == $past(cmp_b))); // R7
endmodule

// File: rtl/upcmp_timer.sv
module upcmp_timer
  import upcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_err,
  output logic              period_pulse,
  output logic              cmpa_pulse,
  output logic              cmpb_pulse
);
  reg_sel_e          sel;
  logic              bad, wr_lo, wr_hi, wr_ma, wr_mb, wr_ca, wr_cb;
  logic [BYTE_W-1:0] lo_byte, hi_byte;
  logic [DATA_W-1:0] cmp_val, cnt, cmp_a, cmp_b;
  logic              run, ev_start, ev_stop;

  assign ev_start = wr_hi && hi_byte[RUN_BIT];
  assign ev_stop  = wr_hi && !hi_byte[RUN_BIT];

  upcmp_decode u_decode (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .size(size), .wdata(wdata),
    .sel(sel), .bad(bad), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ma(wr_ma),
    .wr_mb(wr_mb), .wr_ca(wr_ca), .wr_cb(wr_cb), .lo_byte(lo_byte),
    .hi_byte(hi_byte), .cmp_val(cmp_val)
  );

  upcmp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .size(size), .bad(bad), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ma(wr_ma),
    .wr_mb(wr_mb), .wr_ca(wr_ca), .wr_cb(wr_cb), .lo_byte(lo_byte),
    .hi_byte(hi_byte), .cmp_val(cmp_val), .cnt(cnt), .run(run),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .rdata(rdata), .acc_err(acc_err)
  );

  upcmp_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(ev_start), .stop(ev_stop),
    .run(run), .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt(cnt),
    .period_pulse(period_pulse), .cmpa_pulse(cmpa_pulse), .cmpb_pulse(cmpb_pulse)
  );

  AST_START_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (wr_en && !bad)); // R3
endmodule

// File: tb/upcmp_timer_tb.sv
module upcmp_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] sz = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic acc_err, period_pulse, cmpa_pulse, cmpb_pulse;

  int n_checks = 0, n_errors = 0;
  int tick_mode = 0, tick_div = 0;
  bit chk_on = 0;

  // reference model state
  int m_lo, m_hi, m_ma, m_mb, m_ca, m_cb, m_cnt, m_per;
  int e_per, e_a, e_b, e_err, e_rd;

  always #4 clk = ~clk;

  upcmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr), .rd_en(rd), .addr(addr),
    .size(sz), .wdata(wd), .rdata(rdata), .acc_err(acc_err),
    .period_pulse(period_pulse), .cmpa_pulse(cmpa_pulse), .cmpb_pulse(cmpb_pulse)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit hi_fine(input int b);
    return ((b & 'h07) == 0) && ((b & 'hC0) != 'hC0);
  endfunction

  function automatic bit acc_ok(input bit w, input int a, input int s, input int d);
    if (!(a inside {'h84, 'h85, 'hA4, 'hB4, 'hB5, 'hC4, 'hD4})) return 0;
    if (s > 1) return 0;
    if (s == 1 && !(a inside {'h84, 'hA4, 'hC4, 'hD4})) return 0;
    if (!w) return 1;
    if (a == 'hA4) return 0;
    if (a == 'h84 && (d & 'h2C) != 0) return 0;
    if (a == 'h84 && s == 1 && !hi_fine((d >> 8) & 'hFF)) return 0;
    if (a == 'h85 && !hi_fine(d & 'hFF)) return 0;
    return 1;
  endfunction

  function automatic int rd_val(input int a, input int s);
    case (a)
      'h84: return s ? (m_hi * 256 + m_lo) : m_lo;
      'h85: return m_hi;
      'hA4: return s ? m_cnt : (m_cnt & 'hFF);
      'hB4: return m_ma;
      'hB5: return m_mb;
      'hC4: return s ? m_ca : (m_ca & 'hFF);
      'hD4: return s ? m_cb : (m_cb & 'hFF);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    case (tick_mode)
      1: tick <= 1'b1;
      2: begin tick <= (tick_div == 2); tick_div = (tick_div + 1) % 3; end
      default: tick <= 1'b0;
    endcase
  end

  // behavioural reference model, advanced at each rising edge
  always @(posedge clk) begin
    int ok, hv, touched, nv;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_ma = 0; m_mb = 0; m_ca = 0; m_cb = 0;
      m_cnt = 0; m_per = 65536;
      e_per = 0; e_a = 0; e_b = 0; e_err = 0; e_rd = 0;
    end else begin
      e_per = 0; e_a = 0; e_b = 0; e_err = 0; e_rd = 0;
      ok = (wr || rd) ? acc_ok(wr, addr, sz, wd) : 0;
      if ((wr || rd) && !ok) e_err = 1;
      if (rd && !wr && ok) e_rd = rd_val(addr, sz);
      touched = 0; hv = 0;
      if (wr && ok && addr == 'h85) begin touched = 1; hv = wd & 'hFF; end
      if (wr && ok && addr == 'h84 && sz == 1) begin touched = 1; hv = (wd >> 8) & 'hFF; end
      if ((m_hi & 'h80) && tick && !touched) begin
        nv = m_cnt + 1;
        e_a = ((nv % 65536) == m_ca);
        if (nv == m_per) begin e_per = 1; m_cnt = 0; end
        else m_cnt = nv;
        e_b = (m_cnt == m_cb);
      end
      if (wr && ok) begin
        case (addr)
          'h84: m_lo = wd & 'hFF;
          'hB4: m_ma = wd & 'hFF;
          'hB5: m_mb = wd & 'hFF;
          'hC4: m_ca = sz ? wd : (wd & 'hFF);
          'hD4: m_cb = sz ? wd : (wd & 'hFF);
          default: ;
        endcase
        if (touched) begin
          m_cnt = 0;
          m_hi = hv;
          if (hv & 'h80) m_per = (m_ca == 0) ? 65536 : m_ca;
        end
      end
      if (!(m_hi & 'h80)) m_cnt = 0;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk(period_pulse, e_per, "R5 period pulse vs model");
      chk(cmpa_pulse, e_a, "R6 compare-A pulse vs model");
      chk(cmpb_pulse, e_b, "R7 compare-B pulse vs model");
      chk(acc_err, e_err, "R2 access error vs model");
      chk(rdata, e_rd, "R11 read data vs model");
    end
  end

  // call right after a falling edge; returns after the next falling edge
  task automatic acc(input bit w, input int a, input int s, input int d,
                     output int rv, output int ev);
    wr = w; rd = !w; addr = a[7:0]; sz = s[1:0]; wd = d[15:0];
    @(posedge clk);
    @(negedge clk);
    rv = rdata; ev = acc_err;
    wr = 0; rd = 0;
  endtask

  task automatic count_pulses(input int cycles, output int np, output int na, output int nb);
    np = 0; na = 0; nb = 0;
    repeat (cycles) begin
      @(posedge clk);
      @(negedge clk);
      np += period_pulse; na += cmpa_pulse; nb += cmpb_pulse;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int rv, ev, np, na, nb, n;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1;
    // R1 reset state
    chk(rdata, 0, "R1 rdata after reset");
    chk(period_pulse | cmpa_pulse | cmpb_pulse | acc_err, 0, "R1 outputs after reset");
    acc(0, 'hC4, 1, 0, rv, ev); chk(rv, 0, "R1 compare A reset");
    acc(0, 'h85, 0, 0, rv, ev); chk(rv, 0, "R1 mode high reset");
    acc(0, 'hA4, 1, 0, rv, ev); chk(rv, 0, "R1 counter reset");
    // R2 access errors
    acc(1, 'hA4, 0, 5, rv, ev);    chk(ev, 1, "R2 counter write rejected");
    acc(0, 'hB4, 1, 0, rv, ev);    chk(ev, 1, "R2 halfword at mode A rejected");
    acc(0, 'h40, 0, 0, rv, ev);    chk(ev, 1, "R2 unmapped read rejected");
    chk(rv, 0, "R2 no data on error");
    acc(1, 'hC4, 2, 'h77, rv, ev); chk(ev, 1, "R2 size code 2 rejected");
    acc(0, 'hC4, 1, 0, rv, ev);    chk(rv, 0, "R2 compare A untouched by bad size");
    acc(1, 'hB4, 0, 'h5A, rv, ev); chk(ev, 0, "R2 mode A write accepted");
    acc(1, 'hB5, 0, 'hA5, rv, ev);
    acc(0, 'hB4, 0, 0, rv, ev);    chk(rv, 'h5A, "R2 mode A readback");
    acc(0, 'hB5, 0, 0, rv, ev);    chk(rv, 'hA5, "R2 mode B readback");
    // R3 reserved and conflicting bits
    acc(1, 'h84, 0, 'h04, rv, ev); chk(ev, 1, "R3 low reserved bit 2");
    acc(1, 'h85, 0, 'hC0, rv, ev); chk(ev, 1, "R3 count with load");
    acc(1, 'h85, 0, 'h01, rv, ev); chk(ev, 1, "R3 high reserved bit 0");
    acc(0, 'h84, 1, 0, rv, ev);    chk(rv, 0, "R3 dropped writes leave mode 0");
    acc(1, 'h84, 0, 'hD3, rv, ev); chk(ev, 0, "R3 free low bits accepted");
    acc(0, 'h84, 0, 0, rv, ev);    chk(rv, 'hD3, "R3 low byte readback");
    // R9 zero-extension of byte writes
    acc(1, 'hC4, 1, 'h1234, rv, ev);
    acc(1, 'hC4, 0, 'hAB56, rv, ev);
    acc(0, 'hC4, 1, 0, rv, ev);    chk(rv, 'h0056, "R9 byte write zero-extends");
    // R5/R7 period 4, compare B 2, tick every cycle
    acc(1, 'hC4, 0, 4, rv, ev);
    acc(1, 'hD4, 0, 2, rv, ev);
    tick_mode = 1;
    acc(1, 'h85, 0, 'h80, rv, ev);
    count_pulses(40, np, na, nb);
    chk(np, 10, "R5 period pulses over 40 ticks");
    chk(na, 10, "R6 compare-A pulses over 40 ticks");
    chk(nb, 10, "R7 compare-B pulses over 40 ticks");
    // R6 compare A rewritten while running: period kept
    acc(1, 'hC4, 0, 2, rv, ev);
    acc(0, 'hC4, 0, 0, rv, ev);    chk(rv, 2, "R6 compare A updated live");
    count_pulses(40, np, na, nb);
    chk(np, 10, "R6 period unchanged by compare-A write");
    chk(na, 10, "R6 compare-A pulse follows new value");
    // R10 restart relatches period (now 2)
    acc(1, 'h85, 0, 'h80, rv, ev);
    acc(0, 'hA4, 1, 0, rv, ev);    chk(rv, 0, "R10 count restarted");
    acc(0, 'hA4, 1, 0, rv, ev);    chk(rv, 1, "R4 count after one tick");
    acc(0, 'hA4, 0, 0, rv, ev);    chk(rv, 0, "R5 wrap at new period 2");
    // R8 stop
    acc(1, 'h85, 0, 'h00, rv, ev);
    count_pulses(30, np, na, nb);
    chk(np + na + nb, 0, "R8 no pulses while stopped");
    acc(0, 'hA4, 1, 0, rv, ev);    chk(rv, 0, "R8 counter reads 0 stopped");
    // R4 tick gating: period 3, tick every third cycle
    acc(1, 'hC4, 0, 3, rv, ev);
    tick_mode = 2;
    acc(1, 'h85, 0, 'h80, rv, ev);
    count_pulses(90, np, na, nb);
    chk(np, 10, "R4 period 3 with tick every third cycle");
    // R5 period 0 is 65536 ticks; R9 two-byte mode lanes
    tick_mode = 1;
    acc(1, 'h85, 0, 'h00, rv, ev);
    acc(1, 'hC4, 1, 0, rv, ev);
    acc(1, 'h84, 1, 'h8092, rv, ev);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!period_pulse && n < 70000);
    chk(n, 65536, "R5 zero period spans 65536 ticks");
    acc(0, 'h84, 1, 0, rv, ev);    chk(rv, 'h8092, "R9 two-byte mode read lanes");
    acc(0, 'h84, 0, 0, rv, ev);    chk(rv, 'h92, "R9 byte read of low mode");
    acc(1, 'h85, 0, 'h00, rv, ev);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule